// File: doc/BRIEF.md
# Sensor Command Decoder with Set-Only Calibration Store

This block sits on the device side of a calibrated sensor interface. It takes one 4-bit command per valid cycle, together with a 7-bit address field and a 16-bit data field. It acts on two kinds of state. The first is a 128-bit non-volatile store, modelled here as flip-flops. The second is eight 16-bit working registers. Working register 0 holds the configuration word. Registers 1 to 7 hold calibration coefficients, which are signed 16-bit integers or signed Q15 fractions. The decoder treats them all as plain 16-bit words.

The store behaves like a programmable array. Individual bits can only be set, and only an erase of the whole array brings bits back to zero. A bit set takes effect only after the same set command has been repeated a fixed number of times (default 375) to the same address with no other command in between. This counts the stand-in for a long program pulse. Start-conversion commands carry two flags in their opcode. One selects a reload of the working registers from the store. The other gates the serial data outputs.

Top module: `sensor_cmd_decoder`

## Requirements
- R1: After reset the store and all working registers are zero, `dout_en` is 0 and `conv_start` is 0.
- R2: Opcode 1h loads `cmd_data` into working register `cmd_addr[2:0]`. The new value is visible on `work_regs[16*k +: 16]` from the clock edge that accepts the command. Integer and fraction values are stored bit for bit.
- R3: Opcode 2h targets store bit `cmd_addr`, which is bit `cmd_addr[3:0]` of word `cmd_addr[6:4]`. That bit becomes 1 on the REPEAT-th consecutive 2h command to the same address. A bit that is already 1 stays 1, and no 2h command ever clears a bit.
- R4: Cycles with `cmd_valid` low do not break a run of 2h commands. A 2h command to a different address breaks the run, and so does any accepted non-reserved command of another opcode. After a break the count starts again from one.
- R5: Opcode 4h clears all 128 store bits in one cycle.
- R6: Opcodes 8h, Ah, Ch and Eh raise `conv_start` for exactly one cycle, starting at the edge that accepts the command. No other opcode raises `conv_start`.
- R7: If bit 1 of a start opcode is set (Ah, Eh), every working register k is loaded from store word k (store bits 16k+15 down to 16k). Start opcodes 8h and Ch leave the working registers unchanged.
- R8: A start command sets `dout_en` to the inverse of opcode bit 2. So 8h and Ah enable the outputs, and Ch and Eh disable them. The level holds until the next start command.
- R9: Opcodes 3h, 5h, 6h, 7h, 9h, Bh, Dh and Fh are ignored. They change neither the store nor the working registers, `dout_en` or `conv_start`. They also do not break a run of 2h commands.
- R10: Opcode 0h changes no register or output. It does count as an interrupting command for R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 4 | Command opcode |
| cmd_addr | input | 7 | Store bit address, or working register index in bits 2:0 |
| cmd_data | input | 16 | Coefficient value for opcode 1h |
| conv_start | output | 1 | One-cycle start-of-conversion pulse |
| dout_en | output | 1 | Serial data output enable level |
| work_regs | output | 128 | Working registers, register k in bits 16k+15:16k |

## Verification
The bench sweeps the repetition rule at its edges. One case stops one command short before a no-op, so a decoder that sets the bit early would show a 1 after reload. Another changes the address at the last step. Runs are also split by idle cycles and by reserved opcodes. A decoder that reset its count on those would leave the bit clear. All eight reserved codes and all four start variants are tried in turn, so a wrong flag bit shows up either as reloaded registers or as a wrong `dout_en` level. Store contents are always read back through a reloading start. That path also catches a wrong word-to-register mapping, for example at bits 0 and 127.

// File: rtl/sensor_cmd_decoder.sv
module sensor_cmd_decoder #(
  parameter int WORDS  = 8,
  parameter int WIDTH  = 16,
  parameter int REPEAT = 375
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic [3:0]               cmd_op,
  input  logic [$clog2(WORDS*WIDTH)-1:0] cmd_addr,
  input  logic [WIDTH-1:0]         cmd_data,
  output logic                     conv_start,
  output logic                     dout_en,
  output logic [WORDS*WIDTH-1:0]   work_regs
);
  localparam int BITS = WORDS * WIDTH;
  localparam int AW   = $clog2(BITS);
  localparam int SW   = $clog2(WORDS);
  localparam int CW   = $clog2(REPEAT + 1);

  logic [BITS-1:0]  nvm;
  logic [WIDTH-1:0] wreg [WORDS];
  logic [CW-1:0]    cnt;
  logic [AW-1:0]    last;

  wire is_nop   = cmd_op == 4'h0;
  wire is_wr    = cmd_op == 4'h1;
  wire is_bit   = cmd_op == 4'h2;
  wire is_erase = cmd_op == 4'h4;
  wire is_start = cmd_op[3] & ~cmd_op[0];
  wire known    = is_nop | is_wr | is_bit | is_erase | is_start;
  wire take     = cmd_valid & known;

  wire          same = (cnt != '0) && (last == cmd_addr);
  wire [CW-1:0] nxt  = same ? cnt + 1'b1 : CW'(1);
  wire          done = nxt == CW'(REPEAT);

  for (genvar w = 0; w < WORDS; w++) begin : g_out
    assign work_regs[w*WIDTH +: WIDTH] = wreg[w];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nvm        <= '0;
      cnt        <= '0;
      last       <= '0;
      conv_start <= 1'b0;
      dout_en    <= 1'b0;
      for (int w = 0; w < WORDS; w++) wreg[w] <= '0;
    end else begin
      conv_start <= take & is_start;
      if (take) begin
        if (is_bit) begin
          if (done) begin
            nvm[cmd_addr] <= 1'b1;
            cnt           <= '0;
          end else begin
            cnt  <= nxt;
            last <= cmd_addr;
          end
        end else begin
          cnt <= '0;
        end
        if (is_erase) nvm <= '0;
        if (is_wr) wreg[cmd_addr[SW-1:0]] <= cmd_data;
        if (is_start) begin
          dout_en <= ~cmd_op[2];
          if (cmd_op[1])
            for (int w = 0; w < WORDS; w++) wreg[w] <= nvm[w*WIDTH +: WIDTH];
        end
      end
    end
  end

  assert_reserved_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !known) |=> ($stable(work_regs) && $stable(nvm) && $stable(dout_en)
                               && !conv_start && $stable(cnt)));

  assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(cmd_valid && is_start));

  assert_set_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && is_erase) |=> ((nvm & $past(nvm)) == $past(nvm)));

  assert_erase_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && is_erase) |=> (nvm == '0));

  assert_enable_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && is_start) |=> $stable(dout_en));

  assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(REPEAT));
endmodule

// File: tb/tb_sensor_cmd_decoder.sv
module tb_sensor_cmd_decoder;
  localparam int REP = 375;

  logic         clk = 0, rst_n = 0, cmd_valid = 0;
  logic [3:0]   cmd_op = 0;
  logic [6:0]   cmd_addr = 0;
  logic [15:0]  cmd_data = 0;
  logic         conv_start, dout_en;
  logic [127:0] work_regs;

  int tests = 0, fails = 0;

  logic [127:0] m_store, m_regs;
  logic         m_en;
  int           m_cnt;
  logic [6:0]   m_last;

  sensor_cmd_decoder dut (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .conv_start(conv_start), .dout_en(dout_en),
    .work_regs(work_regs));

  always #5ns clk = ~clk;

  initial begin
    #1500us;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(logic [3:0] op, logic [6:0] a, logic [15:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 0;
    case (op)
      4'h0: m_cnt = 0;
      4'h1: begin m_regs[a[2:0]*16 +: 16] = d; m_cnt = 0; end
      4'h2: begin
        if (m_cnt != 0 && m_last == a) m_cnt++; else m_cnt = 1;
        m_last = a;
        if (m_cnt == REP) begin m_store[a] = 1'b1; m_cnt = 0; end
      end
      4'h4: begin m_store = '0; m_cnt = 0; end
      4'h8, 4'hA, 4'hC, 4'hE: begin
        m_cnt = 0;
        m_en = ~op[2];
        if (op[1]) m_regs = m_store;
      end
      default: ;
    endcase
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic burst(logic [6:0] a, int n);
    for (int i = 0; i < n; i++) send(4'h2, a, 16'h0);
  endtask

  task automatic readback(string req);
    send(4'hA, 7'd0, 16'h0);
    chk(req, work_regs, m_regs);
  endtask

  initial begin
    m_store = '0; m_regs = '0; m_en = 0; m_cnt = 0; m_last = 0;
    idle(3);
    chk("R1 regs", work_regs, '0);
    chk("R1 dout_en", {127'b0, dout_en}, 128'b0);
    chk("R1 conv_start", {127'b0, conv_start}, 128'b0);
    rst_n = 1;
    idle(2);
    chk("R1 regs after release", work_regs, '0);

    for (int k = 0; k < 8; k++) send(4'h1, 7'(k + 8 * k), 16'(k * 16'h1357 + 16'h8001));
    chk("R2 all registers", work_regs, m_regs);
    send(4'h1, 7'd1, 16'h8000);
    send(4'h1, 7'd2, 16'h7FFF);
    chk("R2 signed extremes", work_regs, m_regs);

    send(4'hC, 7'd0, 16'h0);
    chk("R6 pulse Ch", {127'b0, conv_start}, 128'd1);
    chk("R7 Ch keeps regs", work_regs, m_regs);
    chk("R8 Ch disables", {127'b0, dout_en}, {127'b0, m_en});
    idle(1);
    chk("R6 pulse one cycle", {127'b0, conv_start}, 128'b0);
    send(4'h8, 7'd0, 16'h0);
    chk("R7 8h keeps regs", work_regs, m_regs);
    chk("R8 8h enables", {127'b0, dout_en}, 128'd1);

    for (int op = 1; op < 16; op += 2) begin
      if (op == 1) continue;
      send(4'(op), 7'd5, 16'hDEAD);
      chk("R9 reserved no pulse", {127'b0, conv_start}, 128'b0);
      chk("R9 reserved regs", work_regs, m_regs);
      chk("R9 reserved dout_en", {127'b0, dout_en}, {127'b0, m_en});
    end
    foreach (m_store[i]) ;
    for (int op = 5; op < 8; op++) begin
      send(4'(op), 7'd1, 16'hBEEF);
      chk("R9 reserved low regs", work_regs, m_regs);
    end
    send(4'h0, 7'd3, 16'hFFFF);
    chk("R10 nop regs", work_regs, m_regs);
    chk("R10 nop no pulse", {127'b0, conv_start}, 128'b0);

    readback("R7 reload empty store");
    chk("R5 reset store is zero", work_regs, '0);

    burst(7'd0, REP);
    burst(7'd127, REP);
    for (int a = 0; a < 128; a++)
      if (((a * 37 + 11) % 5) == 0) burst(7'(a), REP);
    send(4'hE, 7'd0, 16'h0);
    chk("R3 pattern sweep", work_regs, m_regs);
    chk("R3 bit0 and bit127", {126'b0, work_regs[127], work_regs[0]}, 128'd3);
    chk("R8 Eh disables", {127'b0, dout_en}, 128'b0);

    burst(7'd0, REP);
    readback("R3 set bit stays set");

    burst(7'd50, REP - 1);
    send(4'h0, 7'd50, 16'h0);
    send(4'h2, 7'd50, 16'h0);
    readback("R4 nop breaks run");
    chk("R4 bit 50 still clear", {127'b0, work_regs[50]}, 128'b0);

    burst(7'd51, REP - 1);
    send(4'h2, 7'd52, 16'h0);
    readback("R4 address change breaks run");

    burst(7'd53, 200);
    idle(7);
    burst(7'd53, REP - 200);
    readback("R4 idle keeps run");
    chk("R4 bit 53 set", {127'b0, work_regs[53]}, 128'd1);

    burst(7'd54, 100);
    send(4'h3, 7'd99, 16'h0);
    send(4'hB, 7'd54, 16'h0);
    burst(7'd54, REP - 100);
    readback("R9 reserved keeps run");
    chk("R9 bit 54 set", {127'b0, work_regs[54]}, 128'd1);

    burst(7'd60, REP - 1);
    send(4'h4, 7'd0, 16'h0);
    send(4'h2, 7'd60, 16'h0);
    readback("R5 erase clears and breaks run");
    chk("R5 all zero", work_regs, '0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule